// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns an effective address into a real address by walking in-memory translation tables. A request carries the base and size code of a process table, a process identifier and the effective address. The walker first fetches the process-table entry chosen by the identifier, which names the root of a radix tree and the total address-size exponent. It then descends the tree one level per memory read. Every directory entry states the fan-out of the level below, so the tree's shape and the final page size both come from the table contents rather than from fixed parameters.

A finished walk returns the real address, the page-size exponent left over at the leaf, the leaf entry itself and the address it was read from. A walk that cannot finish returns a fault code instead. Requests enter on a valid/ready pair: `in_valid` must stay high with stable fields until `in_ready` is seen, and `in_ready` is high only while the walker is idle. Results leave on a valid/ready pair: `out_valid` and all result fields hold until `out_ready` is sampled high. Memory reads use a request valid/ready pair with one read in flight at most, and a single-cycle response strobe that has no back-pressure.

Top module: `radix_walker`

## Requirements
- R1: `in_ready` is high only while idle (never together with `out_valid` or `mem_req_valid`); a result stays on the outputs, unchanged, until `out_ready` is high at a clock edge, after which the walker is idle again.
- R2: The process-table span is 2^(`in_prts`+12) bytes; when `in_pid`×16 is at or beyond it, the walk ends with the no-entry fault (`out_fault` = 2'b01) and issues no memory read.
- R3: Otherwise the first read is at `in_prtb` + `in_pid`×16; from that doubleword, bits [61:56] give the starting shift count, bits [55:8] the root base (low 8 address bits zero) and bits [7:0] the root index size.
- R4: Before each level read, an index size below 5 or above the remaining shift count ends the walk with the bad-configuration fault (`out_fault` = 2'b10).
- R5: A level read goes to base + (((ea >> (shift − size)) masked to size bits) × 8); effective-address bits above the shift count have no effect.
- R6: A tree entry with bit 63 clear ends the walk with the no-entry fault.
- R7: A valid entry with bit 62 set is a leaf: `out_psize` = shift − size, `out_raddr` = ({entry[55:12], 12'b0} with its low `out_psize` bits cleared) OR (the low `out_psize` bits of ea), `out_pte` = the entry, `out_pte_addr` = its read address, `out_fault` = 0.
- R8: A valid non-leaf entry makes {entry[55:8], 8'b0} the next base and entry[7:0] the next index size, and the walk continues with the reduced shift count.
- R9: At most 8 tree levels are read per walk; when an 8th level yields no leaf, the walk ends with the bad-configuration fault and no 9th level read is issued.
- R10: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready`; no new read starts before the response to the previous one; `mem_rsp_valid` is ignored while no read is in flight.
- R11: On any fault, `out_raddr`, `out_psize`, `out_pte` and `out_pte_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Walk request present |
| in_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| in_prtb | input | PA_W | Process-table base address |
| in_prts | input | 5 | Process-table size code (span 2^(code+12) bytes) |
| in_pid | input | PID_W | Process identifier |
| in_ea | input | EA_W | Effective address to translate |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the doubleword to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_raddr | output | PA_W | Translated real address |
| out_psize | output | 6 | Page-size exponent at the leaf |
| out_pte | output | 64 | Leaf entry |
| out_pte_addr | output | PA_W | Address the leaf entry was read from |
| out_fault | output | 2 | Bit 0 no-entry, bit 1 bad configuration |

## Verification
The bench aims at the edges of each limit: the identifier one below and exactly at the table span (an off-by-one bound would either read past the table or fault on the last legal entry), a level with index size 4 and one whose size exceeds the remaining shift (a walker without these checks would compute a negative shift and read garbage). It runs one walk that finds its leaf on the 8th level and another that needs a 9th, so a miscounted bound either kills a legal walk or reads one level too many, visible in the read count. Leaves at the first and second level, with effective addresses whose high bits are set, catch a mask taken from the wrong shift value, which would leak address bits or drop page-offset bits. Stalled memory acceptance and a held-off consumer catch a walker that drops its request or changes its result before the handshake.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PT_REQ,
    ST_PT_WAIT,
    ST_LV_CHK,
    ST_LV_REQ,
    ST_LV_WAIT,
    ST_DONE
  } walk_state_e;

  localparam int ENT_W      = 64;
  localparam int BIT_VALID  = 63;
  localparam int BIT_LEAF   = 62;
  localparam int SHIFT_W    = 6;
  localparam int SIZE_W     = 8;
  localparam int PRTS_W     = 5;
  localparam int MIN_SIZE   = 5;
  localparam int FLT_NOENT  = 0;
  localparam int FLT_BADCFG = 1;
endpackage

// File: rtl/radix_pt_locate.sv
module radix_pt_locate #(
  parameter int PA_W  = 56,
  parameter int PID_W = 20
) (
  input  logic [PA_W-1:0]                         prtb,
  input  logic [radix_walker_pkg::PRTS_W-1:0]     prts,
  input  logic [PID_W-1:0]                        pid,
  output logic [PA_W-1:0]                         addr,
  output logic                                    out_of_range
);
  logic [63:0] offset;
  logic [5:0]  span_exp;

  always_comb begin
    offset       = 64'(pid) << 4;
    span_exp     = 6'(prts) + 6'd12;
    out_of_range = (offset >> span_exp) != 64'd0;
    addr         = prtb + PA_W'(offset);
  end
endmodule

// File: rtl/radix_level_index.sv
module radix_level_index #(
  parameter int EA_W = 64,
  parameter int PA_W = 56
) (
  input  logic [EA_W-1:0] ea,
  input  logic [PA_W-1:0] base,
  input  logic [5:0]      shift,
  input  logic [5:0]      size,
  output logic [PA_W-1:0] addr
);
  logic [63:0]     ea64;
  logic [63:0]     idx_mask;
  logic [5:0]      drop;
  logic [PA_W-1:0] idx;

  always_comb begin
    ea64     = 64'(ea);
    drop     = shift - size;
    idx_mask = (64'd1 << size) - 64'd1;
    idx      = PA_W'((ea64 >> drop) & idx_mask);
    addr     = base + (idx << 3);
  end
endmodule

// File: rtl/radix_leaf_compose.sv
module radix_leaf_compose #(
  parameter int EA_W = 64,
  parameter int PA_W = 56
) (
  input  logic [EA_W-1:0] ea,
  input  logic [43:0]     rpn,
  input  logic [5:0]      psize,
  output logic [PA_W-1:0] raddr
);
  logic [63:0] ea64;
  logic [63:0] page_base;
  logic [63:0] off_mask;

  always_comb begin
    ea64      = 64'(ea);
    page_base = {8'd0, rpn, 12'd0};
    off_mask  = (64'd1 << psize) - 64'd1;
    raddr     = PA_W'((page_base & ~off_mask) | (ea64 & off_mask));
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walker_pkg::*;
#(
  parameter int EA_W       = 64,
  parameter int PA_W       = 56,
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PA_W-1:0]   in_prtb,
  input  logic [4:0]        in_prts,
  input  logic [PID_W-1:0]  in_pid,
  input  logic [EA_W-1:0]   in_ea,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_raddr,
  output logic [5:0]        out_psize,
  output logic [63:0]       out_pte,
  output logic [PA_W-1:0]   out_pte_addr,
  output logic [1:0]        out_fault
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  walk_state_e          state_q;
  logic [EA_W-1:0]      ea_q;
  logic [PA_W-1:0]      base_q;
  logic [SIZE_W-1:0]    size_q;
  logic [SHIFT_W-1:0]   shift_q;
  logic [LVL_W-1:0]     lvl_q;
  logic [PA_W-1:0]      addr_q;
  logic [PA_W-1:0]      raddr_q;
  logic [5:0]           psize_q;
  logic [63:0]          pte_q;
  logic [PA_W-1:0]      pte_addr_q;
  logic [1:0]           fault_q;

  logic [PA_W-1:0]      pt_addr;
  logic                 pt_oob;
  logic [PA_W-1:0]      lvl_addr;
  logic [PA_W-1:0]      leaf_raddr;
  logic [SHIFT_W-1:0]   shift_after;
  logic                 cfg_bad;
  logic [63:0]          entry_base;
  logic [PA_W-1:0]      next_base;

  radix_pt_locate #(.PA_W(PA_W), .PID_W(PID_W)) u_locate (
    .prtb         (in_prtb),
    .prts         (in_prts),
    .pid          (in_pid),
    .addr         (pt_addr),
    .out_of_range (pt_oob)
  );

  radix_level_index #(.EA_W(EA_W), .PA_W(PA_W)) u_index (
    .ea    (ea_q),
    .base  (base_q),
    .shift (shift_q),
    .size  (size_q[5:0]),
    .addr  (lvl_addr)
  );

  radix_leaf_compose #(.EA_W(EA_W), .PA_W(PA_W)) u_leaf (
    .ea    (ea_q),
    .rpn   (mem_rsp_data[55:12]),
    .psize (shift_after),
    .raddr (leaf_raddr)
  );

  always_comb begin
    shift_after = shift_q - size_q[5:0];
    cfg_bad     = (size_q < SIZE_W'(MIN_SIZE))
               || (size_q > SIZE_W'(shift_q))
               || (lvl_q == LVL_W'(MAX_LEVELS));
    entry_base  = {8'd0, mem_rsp_data[55:8], 8'd0};
    next_base   = PA_W'(entry_base);
  end

  assign in_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_PT_REQ) || (state_q == ST_LV_REQ);
  assign mem_req_addr  = addr_q;
  assign out_valid     = (state_q == ST_DONE);
  assign out_raddr     = raddr_q;
  assign out_psize     = psize_q;
  assign out_pte       = pte_q;
  assign out_pte_addr  = pte_addr_q;
  assign out_fault     = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ea_q       <= '0;
      base_q     <= '0;
      size_q     <= '0;
      shift_q    <= '0;
      lvl_q      <= '0;
      addr_q     <= '0;
      raddr_q    <= '0;
      psize_q    <= '0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      fault_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            ea_q       <= in_ea;
            raddr_q    <= '0;
            psize_q    <= '0;
            pte_q      <= '0;
            pte_addr_q <= '0;
            fault_q    <= '0;
            if (pt_oob) begin
              fault_q[FLT_NOENT] <= 1'b1;
              state_q            <= ST_DONE;
            end else begin
              addr_q  <= pt_addr;
              state_q <= ST_PT_REQ;
            end
          end
        end
        ST_PT_REQ: begin
          if (mem_req_ready) state_q <= ST_PT_WAIT;
        end
        ST_PT_WAIT: begin
          if (mem_rsp_valid) begin
            base_q  <= next_base;
            size_q  <= mem_rsp_data[7:0];
            shift_q <= mem_rsp_data[61:56];
            lvl_q   <= '0;
            state_q <= ST_LV_CHK;
          end
        end
        ST_LV_CHK: begin
          if (cfg_bad) begin
            fault_q[FLT_BADCFG] <= 1'b1;
            state_q             <= ST_DONE;
          end else begin
            addr_q  <= lvl_addr;
            state_q <= ST_LV_REQ;
          end
        end
        ST_LV_REQ: begin
          if (mem_req_ready) state_q <= ST_LV_WAIT;
        end
        ST_LV_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[BIT_VALID]) begin
              fault_q[FLT_NOENT] <= 1'b1;
              state_q            <= ST_DONE;
            end else if (mem_rsp_data[BIT_LEAF]) begin
              raddr_q    <= leaf_raddr;
              psize_q    <= shift_after;
              pte_q      <= mem_rsp_data;
              pte_addr_q <= addr_q;
              state_q    <= ST_DONE;
            end else begin
              base_q  <= next_base;
              size_q  <= mem_rsp_data[7:0];
              shift_q <= shift_after;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= ST_LV_CHK;
            end
          end
        end
        ST_DONE: begin
          if (out_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int EA_W  = 64,
  parameter int PA_W  = 56,
  parameter int PID_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PA_W-1:0]  in_prtb,
  input logic [4:0]       in_prts,
  input logic [PID_W-1:0] in_pid,
  input logic [EA_W-1:0]  in_ea,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [63:0]      mem_rsp_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PA_W-1:0]  out_raddr,
  input logic [5:0]       out_psize,
  input logic [63:0]      out_pte,
  input logic [PA_W-1:0]  out_pte_addr,
  input logic [1:0]       out_fault
);
  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_req_valid && !out_valid)); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_raddr) && $stable(out_fault)
                                   && $stable(out_pte) && $stable(out_psize)
                                   && $stable(out_pte_addr))); // R1

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R10

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault != 2'b00) |-> (out_raddr == '0 && out_psize == 6'd0
                                           && out_pte == 64'd0 && out_pte_addr == '0)); // R11

  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_fault)); // R4

  AST_LEAF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault == 2'b00) |-> (out_pte[63] && out_pte[62])); // R7

  AST_LEAF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault == 2'b00) |-> (out_pte_addr[2:0] == 3'd0)); // R5
endmodule

bind radix_walker radix_walker_chk #(.EA_W(EA_W), .PA_W(PA_W), .PID_W(PID_W)) u_chk (.*);

// File: tb/radix_walker_test.sv
`timescale 1ns/1ps
module radix_walker_test;
  localparam int EA_W  = 64;
  localparam int PA_W  = 56;
  localparam int PID_W = 20;
  localparam int NV    = 15;

  typedef struct packed {
    logic [55:0] prtb;
    logic [4:0]  prts;
    logic [19:0] pid;
    logic [63:0] ea;
    logic [1:0]  fault;
    logic [55:0] raddr;
    logic [5:0]  psize;
    logic [55:0] paddr;
    logic [3:0]  nreads;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0000_0ABC, 2'b00, 56'h75ABC,   6'd12, 56'h200, 4'd3},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0000_5FF0, 2'b00, 56'h123FF0,  6'd12, 56'h228, 4'd3},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_000A_1234, 2'b00, 56'hAA1234,  6'd19, 56'h108, 4'd2},
    '{56'h0,  5'd0, 20'd0,   64'hFFFF_0000_0000_0ABC, 2'b00, 56'h75ABC,   6'd12, 56'h200, 4'd3},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0010_0000, 2'b01, 56'h0,       6'd0,  56'h0,   4'd2},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0000_9000, 2'b01, 56'h0,       6'd0,  56'h0,   4'd3},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0018_0000, 2'b10, 56'h0,       6'd0,  56'h0,   4'd2},
    '{56'h0,  5'd0, 20'd0,   64'h0000_0000_0020_0000, 2'b10, 56'h0,       6'd0,  56'h0,   4'd2},
    '{56'h0,  5'd0, 20'd1,   64'h0,                   2'b10, 56'h0,       6'd0,  56'h0,   4'd1},
    '{56'h0,  5'd0, 20'd2,   64'h0000_0000_0001_2345, 2'b10, 56'h0,       6'd0,  56'h0,   4'd9},
    '{56'h0,  5'd0, 20'd3,   64'h0000_0000_0001_2345, 2'b00, 56'h1812345, 6'd23, 56'hE00, 4'd9},
    '{56'h0,  5'd0, 20'd255, 64'h0,                   2'b10, 56'h0,       6'd0,  56'h0,   4'd1},
    '{56'h0,  5'd0, 20'd256, 64'h0,                   2'b01, 56'h0,       6'd0,  56'h0,   4'd0},
    '{56'h10, 5'd0, 20'd2,   64'h0000_0000_0001_2345, 2'b00, 56'h1812345, 6'd23, 56'hE00, 4'd9},
    '{56'h0,  5'd1, 20'd256, 64'h0000_0000_0000_0ABC, 2'b00, 56'h75ABC,   6'd12, 56'h200, 4'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [PA_W-1:0]   in_prtb;
  logic [4:0]        in_prts;
  logic [PID_W-1:0]  in_pid;
  logic [EA_W-1:0]   in_ea;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              out_valid;
  logic              out_ready;
  logic [PA_W-1:0]   out_raddr;
  logic [5:0]        out_psize;
  logic [63:0]       out_pte;
  logic [PA_W-1:0]   out_pte_addr;
  logic [1:0]        out_fault;

  logic [63:0]       mem [512];
  int                cyc;
  int                reads;
  logic [PA_W-1:0]   addr_log [16];
  int                n_checks;
  int                n_fails;

  always #2.5 clk = ~clk;

  radix_walker #(.EA_W(EA_W), .PA_W(PA_W), .PID_W(PID_W), .MAX_LEVELS(8)) uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_prtb, .in_prts, .in_pid, .in_ea,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .out_valid, .out_ready, .out_raddr, .out_psize, .out_pte, .out_pte_addr, .out_fault
  );

  assign mem_req_ready = (cyc % 3) != 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc           <= 0;
      reads         <= 0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= 64'd0;
    end else begin
      cyc <= cyc + 1;
      if (mem_req_valid && mem_req_ready) begin
        reads                  <= reads + 1;
        addr_log[reads % 16]   <= mem_req_addr;
        mem_rsp_valid          <= 1'b1;
        mem_rsp_data           <= mem[mem_req_addr[11:3]];
      end else begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_data  <= 64'hDEAD_BEEF_DEAD_BEEF;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int r0;
    logic [55:0] first_exp;
    logic [63:0] pte_exp;
    logic [55:0] hold_raddr;
    logic [1:0]  hold_fault;
    string ftag;
    v = VECS[i];
    @(negedge clk);
    in_prtb  = v.prtb;
    in_prts  = v.prts;
    in_pid   = v.pid;
    in_ea    = v.ea;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    r0 = reads;
    @(negedge clk);
    in_valid = 1'b0;
    in_ea    = '1;
    in_pid   = '1;
    check(!in_ready, "R1 busy after accept", 64'(in_ready), 64'd0);
    while (!out_valid) @(negedge clk);
    case (v.fault)
      2'b01:   ftag = "R2/R6 no-entry fault";
      2'b10:   ftag = "R4/R9 bad-config fault";
      default: ftag = "R7 leaf fault code";
    endcase
    check(out_fault == v.fault, ftag, 64'(out_fault), 64'(v.fault));
    check(out_raddr == v.raddr, "R7/R11 real address", 64'(out_raddr), 64'(v.raddr));
    check(out_psize == v.psize, "R7/R11 page size", 64'(out_psize), 64'(v.psize));
    check(out_pte_addr == v.paddr, "R7/R11 entry address", 64'(out_pte_addr), 64'(v.paddr));
    pte_exp = (v.fault == 2'b00) ? mem[v.paddr[11:3]] : 64'd0;
    check(out_pte == pte_exp, "R7/R11 leaf entry", out_pte, pte_exp);
    check(reads - r0 == int'(v.nreads), "R2 R5 R8 R9 read count",
          64'(reads - r0), 64'(v.nreads));
    if (v.nreads != 0) begin
      first_exp = v.prtb + (56'(v.pid) << 4);
      check(addr_log[r0 % 16] == first_exp, "R3 process entry address",
            64'(addr_log[r0 % 16]), 64'(first_exp));
    end
    hold_raddr = out_raddr;
    hold_fault = out_fault;
    repeat (2) @(negedge clk);
    check(out_valid && !in_ready && out_raddr == hold_raddr && out_fault == hold_fault,
          "R1 result held", 64'(out_raddr), 64'(hold_raddr));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1 release to idle", 64'({out_valid, in_ready}), 64'b01);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    for (int k = 0; k < 512; k++) mem[k] = 64'd0;
    mem[0]   = 64'h1800_0000_0000_0105;
    mem[2]   = 64'h1800_0000_0000_0103;
    mem[4]   = 64'h3F00_0000_0000_0605;
    mem[6]   = 64'h3F00_0000_0000_0705;
    mem[32]  = 64'h8000_0000_0000_0207;
    mem[33]  = 64'hC000_0000_00A8_3000;
    mem[35]  = 64'h8000_0000_0000_0204;
    mem[36]  = 64'h8000_0000_0000_0614;
    mem[64]  = 64'hC000_0000_0007_5000;
    mem[69]  = 64'hC000_0000_0012_3000;
    for (int k = 0; k < 8; k++)
      mem[192 + k*32] = 64'h8000_0000_0000_0005 | 64'(32'h700 + k*256);
    mem[448] = 64'hC000_0000_0180_5000;

    rst_n     = 1'b0;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    in_prtb   = '0;
    in_prts   = '0;
    in_pid    = '0;
    in_ea     = '0;
    repeat (4) @(negedge clk);
    check(!out_valid && !mem_req_valid, "R1 reset outputs", 64'({out_valid, mem_req_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R1 idle after reset", 64'(in_ready), 64'd1);
    check(out_fault == 2'b00 && out_raddr == '0, "R11 reset result", 64'(out_fault), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: a stray response strobe while idle must not start or change anything
    @(negedge clk);
    force mem_rsp_valid = 1'b1;
    repeat (3) @(negedge clk);
    release mem_rsp_valid;
    @(negedge clk);
    check(in_ready && !out_valid && !mem_req_valid, "R10 stray response ignored",
          64'({in_ready, out_valid, mem_req_valid}), 64'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule